// File: doc/BRIEF.md
# Inter-Processor Interrupt Doorbell

This block lets a host processor ring up to 28 doorbells toward one target core. The host reaches it through a single 32-bit register on a simple synchronous bus. Writing a 1 into a doorbell bit makes that line's interrupt pending. The pending line drives a level interrupt toward the target. The target clears a line by pulsing that line's acknowledge input.

Reading the register does not return what was last written. It returns the live status of every doorbell: 1 while the target has not yet handled the interrupt, 0 once it has. The host can therefore poll to learn when each request has been serviced.

The host cannot withdraw a request. Writing 0 leaves a line unchanged, and the four bits above the doorbell field are reserved. If a host set and a target acknowledge land on the same line in the same cycle, the set takes priority, so a fresh request is never lost.

Top module: `ipc_doorbell`

## Requirements
- R1: While synchronous active-high reset `rst` is sampled high, every pending bit clears at that edge. After such an edge, `tgtIrq` is all zero and `busRdData` is zero.
- R2: A write (`busWrEn`=1) that hits the register window makes line i pending at the next rising edge for each i in 0..27 where `busWrData[i]`=1. From that edge on, `tgtIrq[i]` is 1.
- R3: Writing 0 to a doorbell bit leaves that line's pending state unchanged. The host cannot cancel a pending interrupt.
- R4: A pulse on `tgtAck[i]`, with no set of line i in the same cycle, clears line i at the next rising edge.
- R5: When a set and an acknowledge of the same line occur in the same cycle, the line is pending after the edge.
- R6: `tgtIrq[i]` is a level equal to line i's pending bit. It holds steady while neither a set nor an acknowledge of that line occurs.
- R7: A read (`busRdEn`=1) that hits the window returns its result in `busRdData` one cycle later. Bit i (0..27) holds line i's pending state as it stood before that edge, and bits 31:28 read as 0.
- R8: The window is the 4-byte word at byte offset `REG_OFFSET`, and address bits 1:0 are ignored. A write or read at any other word has no effect: the write sets no line, and the read returns 0.
- R9: Write data bits 31:28 are ignored and change no state.
- R10: In a cycle following one with no read hit, `busRdData` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| busAddr | input | ADDR_W | Byte address of the access |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 32 | Write data; a 1 in bits 27:0 rings that doorbell |
| busRdEn | input | 1 | Read strobe, one cycle per read |
| busRdData | output | 32 | Read data, valid the cycle after the read strobe |
| tgtAck | input | 28 | Per-line handled pulse from the target core |
| tgtIrq | output | 28 | Per-line level interrupt toward the target core |

## Verification
The bench builds the block with its defaults: a 12-bit address and the window at offset 0x040. With these values, the word addresses just below and just above the window are easy to reach, and so are misaligned byte addresses that still fall inside it. Because the 28 doorbell lines leave four reserved bits in the 32-bit word, writes and reads of bits 31:28 can be exercised directly. A behavioural model tracks pending state and read data every clock under directed and pseudo-random writes, acknowledges and reads. The random traffic includes collisions between sets and acknowledges on the same line.

// File: rtl/ipc_doorbell_pkg.sv
package ipc_doorbell_pkg;
  // number of doorbell lines toward the target core
  localparam int LINES  = 28;
  // width of the host register
  localparam int DATA_W = 32;

  // strobes from the bus control to the pending datapath
  typedef struct packed {
    logic [LINES-1:0] setMask;   // lines to raise this cycle
    logic             rdHit;     // a read hits the window
  } dbStrobe_t;
endpackage

// File: rtl/ipc_doorbell_ctrl.sv
module ipc_doorbell_ctrl
  import ipc_doorbell_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int REG_OFFSET = 'h040
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRdEn,
  output dbStrobe_t         strobe
);
  localparam logic [ADDR_W-1:0] WIN_ADDR = ADDR_W'(REG_OFFSET);

  logic winHit;
  logic unusedBits;

  // word-level decode; the byte lane bits do not take part
  assign winHit = (busAddr[ADDR_W-1:2] == WIN_ADDR[ADDR_W-1:2]);

  // reserved write bits and the byte lane bits feed nothing
  assign unusedBits = ^{busAddr[1:0], busWrData[DATA_W-1:LINES]};

  always_comb begin
    strobe         = '0;
    strobe.rdHit   = winHit && busRdEn;
    if (winHit && busWrEn) begin
      strobe.setMask = busWrData[LINES-1:0];
    end
  end

  // accesses outside the window raise nothing
  assert_decode_miss_R8: assert property (@(posedge clk) disable iff (rst)
    (busAddr[ADDR_W-1:2] != WIN_ADDR[ADDR_W-1:2]) |-> (strobe.setMask == '0 && !strobe.rdHit));

  // a write strobe without a write enable never sets a line
  assert_no_set_without_write_R3: assert property (@(posedge clk) disable iff (rst)
    !busWrEn |-> (strobe.setMask == '0));
endmodule

// File: rtl/ipc_doorbell_datapath.sv
module ipc_doorbell_datapath
  import ipc_doorbell_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  dbStrobe_t        strobe,
  input  logic [LINES-1:0] tgtAck,
  output logic [LINES-1:0] pending,
  output logic [DATA_W-1:0] rdData
);
  // one pending flop per doorbell line; set has priority over acknowledge
  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        pending[i] <= 1'b0;
      end else if (strobe.setMask[i]) begin
        pending[i] <= 1'b1;
      end else if (tgtAck[i]) begin
        pending[i] <= 1'b0;
      end
    end
  end

  // zero-extended status word
  logic [DATA_W-1:0] statusWord;
  if (DATA_W > LINES) begin : g_pad
    assign statusWord = {{(DATA_W-LINES){1'b0}}, pending};
  end else begin : g_nopad
    assign statusWord = pending[DATA_W-1:0];
  end

  // read data captures the status seen at the edge of the read
  always_ff @(posedge clk) begin
    if (rst) begin
      rdData <= '0;
    end else if (strobe.rdHit) begin
      rdData <= statusWord;
    end else begin
      rdData <= '0;
    end
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (pending == '0 && rdData == '0));

  assert_set_raises_R2: assert property (@(posedge clk) disable iff (rst)
    (strobe.setMask != '0) |=> ((pending & $past(strobe.setMask)) == $past(strobe.setMask)));

  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (rst)
    ((tgtAck & ~strobe.setMask) != '0) |=> ((pending & $past(tgtAck & ~strobe.setMask)) == '0));

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
    ((tgtAck & strobe.setMask) != '0) |=> ((pending & $past(tgtAck & strobe.setMask)) == $past(tgtAck & strobe.setMask)));

  assert_hold_level_R6: assert property (@(posedge clk) disable iff (rst)
    (strobe.setMask == '0 && tgtAck == '0) |=> $stable(pending));

  assert_idle_read_zero_R10: assert property (@(posedge clk) disable iff (rst)
    !strobe.rdHit |=> (rdData == '0));
endmodule

// File: rtl/ipc_doorbell.sv
module ipc_doorbell
  import ipc_doorbell_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int REG_OFFSET = 'h040
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  input  logic              busRdEn,
  output logic [31:0]       busRdData,
  input  logic [27:0]       tgtAck,
  output logic [27:0]       tgtIrq
);
  dbStrobe_t        strobe;
  logic [LINES-1:0] pending;

  ipc_doorbell_ctrl #(
    .ADDR_W    (ADDR_W),
    .REG_OFFSET(REG_OFFSET)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .busAddr  (busAddr),
    .busWrEn  (busWrEn),
    .busWrData(busWrData),
    .busRdEn  (busRdEn),
    .strobe   (strobe)
  );

  ipc_doorbell_datapath u_datapath (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .tgtAck (tgtAck),
    .pending(pending),
    .rdData (busRdData)
  );

  // interrupt outputs are the pending levels
  assign tgtIrq = pending;

  assert_reserved_read_zero_R7: assert property (@(posedge clk) disable iff (rst)
    busRdData[31:28] == 4'h0);

  assert_read_matches_status_R7: assert property (@(posedge clk) disable iff (rst)
    strobe.rdHit |=> (busRdData[27:0] == $past(tgtIrq)));
endmodule

// File: tb/ipc_doorbell_bench.sv
module ipc_doorbell_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW         = 12;
  localparam int WIN        = 'h040;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] busAddr;
  logic          busWrEn;
  logic [31:0]   busWrData;
  logic          busRdEn;
  logic [31:0]   busRdData;
  logic [27:0]   tgtAck;
  logic [27:0]   tgtIrq;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  logic [27:0] modelPend;
  logic [31:0] modelRd;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipc_doorbell #(.ADDR_W(AW), .REG_OFFSET(WIN)) u_ipc_doorbell (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .tgtAck(tgtAck), .tgtIrq(tgtIrq)
  );

  task automatic compare(input string tag);
    checks++;
    if (tgtIrq !== modelPend || busRdData !== modelRd) begin
      errors++;
      $display("FAIL %s: irq=%h rd=%h expected irq=%h rd=%h",
               tag, tgtIrq, busRdData, modelPend, modelRd);
    end
  endtask

  // drive one cycle after a falling edge, step the model, compare at the next falling edge
  task automatic cycle(input string tag, input logic [AW-1:0] a, input logic we,
                       input logic [31:0] wd, input logic re, input logic [27:0] ack);
    bit hit;
    logic [27:0] setv;
    busAddr = a; busWrEn = we; busWrData = wd; busRdEn = re; tgtAck = ack;
    hit = (a[AW-1:2] == AW'(WIN) >> 2);
    setv = (we && hit) ? wd[27:0] : 28'h0;
    modelRd = (re && hit) ? {4'h0, modelPend} : 32'h0;
    modelPend = (modelPend & ~ack) | setv;
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input string tag);
    cycle(tag, AW'(WIN), 1'b0, 32'h0, 1'b0, 28'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    rst = 1'b1;
    busAddr = '0; busWrEn = 0; busWrData = '0; busRdEn = 0; tgtAck = '0;
    @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    modelPend = '0; modelRd = '0;
    compare("R1 reset state");
    rst = 1'b0;

    // R2: set several patterns and read back (R7)
    cycle("R2 set low bits", AW'(WIN), 1, 32'h0000_0005, 0, 0);
    cycle("R2 set high line", AW'(WIN), 1, 32'h0800_0000, 0, 0);
    cycle("R7 read status", AW'(WIN), 0, 0, 1, 0);
    cycle("R7 read on misaligned byte", AW'(WIN + 3), 0, 0, 1, 0);
    // R6: level held while idle
    idle("R6 hold");
    idle("R6 hold");
    cycle("R10 no read gives zero", AW'(WIN), 0, 0, 0, 0);
    // R3: writing zeros keeps pending lines
    cycle("R3 write zeros", AW'(WIN), 1, 32'h0, 0, 0);
    cycle("R3 read after zero write", AW'(WIN), 0, 0, 1, 0);
    // R4: acknowledge clears
    cycle("R4 ack line0", AW'(WIN), 0, 0, 0, 28'h000_0001);
    cycle("R4 ack line27", AW'(WIN), 0, 0, 1, 28'h800_0000);
    // R5: collision, set wins
    cycle("R5 set+ack same line", AW'(WIN), 1, 32'h0000_0010, 0, 28'h000_0014);
    cycle("R5 read after collision", AW'(WIN), 0, 0, 1, 0);
    // R7 read sees state before same-edge update
    cycle("R7 read with same-cycle ack", AW'(WIN), 0, 0, 1, 28'h000_0010);
    cycle("R7 read with same-cycle set", AW'(WIN), 1, 32'h0000_0100, 1, 0);
    // R8: other words ignored
    cycle("R8 write below window", AW'(WIN - 4), 1, 32'h0FFF_FFFF, 0, 0);
    cycle("R8 write above window", AW'(WIN + 4), 1, 32'h0FFF_FFFF, 0, 0);
    cycle("R8 read outside window", AW'(WIN + 4), 0, 0, 1, 0);
    cycle("R8 read back after stray writes", AW'(WIN), 0, 0, 1, 0);
    // R9: reserved write bits ignored
    cycle("R9 write reserved bits", AW'(WIN), 1, 32'hF000_0000, 0, 0);
    cycle("R9 read after reserved write", AW'(WIN), 0, 0, 1, 0);
    cycle("R7 set all then read", AW'(WIN), 1, 32'hFFFF_FFFF, 0, 0);
    cycle("R7 all lines read", AW'(WIN), 0, 0, 1, 0);
    // R1: reset mid-run clears everything
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    modelPend = '0; modelRd = '0;
    rst = 1'b0;
    compare("R1 reset after activity");

    // pseudo-random traffic
    lfsr = 32'hACE1_2345;
    for (int n = 0; n < 600; n++) begin
      logic [31:0] r1, r2;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      r1 = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      r2 = lfsr;
      cycle("R2 R4 R5 random traffic",
            (r1[3:0] == 4'h0) ? AW'(WIN + 8) : AW'(WIN + (r1[5:4])),
            r1[6], r1 & r2, r1[7], r2[27:0] & {28{r2[31]}});
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule